// File: doc/BRIEF.md
# Frexp-Style Operand Decomposition Unit

This unit splits one single-precision operand into the starting values that reciprocal, square-root and reciprocal-square-root iterations need. It treats a finite nonzero operand as m·2^e, with m in [1,2) and e the unbiased exponent. Subnormal operands are first normalised with a leading-zero count, so their e lies below −126. A 3-bit operation code chooses one of two kinds of result. The first kind is a rescaled float mantissa that keeps the operand's sign. The second is a 32-bit two's-complement integer exponent term that a later ldexp-style step applies.

The result is registered. A code presented in one cycle produces its result after the next rising clock edge. Zero, infinity and NaN give fixed values in every mode, so the iteration that follows needs no separate special-case path.

Top module: `frexp_unit`

## Requirements
- R1: While rst_ni is low, result_o is 0. A result appears on result_o one rising clock edge after its op_i and operand_i are presented.
- R2: With op_i = 0 (reciprocal mantissa) and a finite nonzero operand, result_o is m·2^-1. The sign is unchanged, the exponent field [30:23] is 126, and the fraction field [22:0] holds the fraction of m.
- R3: With op_i = 1 (square-root mantissa) and a finite nonzero operand, result_o is m·2^-2 when e is even (exponent field 125) and m·2^-1 when e is odd (exponent field 126). The sign and fraction of m are kept.
- R4: With op_i = 2 (reciprocal exponent) and a finite nonzero operand, result_o is the integer −e−1.
- R5: With op_i = 3 (square-root exponent) and a finite nonzero operand, result_o is floor(e/2)+1, where floor rounds toward minus infinity.
- R6: With op_i = 4 (reciprocal-square-root exponent) and a finite nonzero operand, result_o is −floor(e/2)−1.
- R7: In op_i modes 2, 3 and 4, a zero, infinite or NaN operand gives result_o = 0.
- R8: In op_i modes 0 and 1, a zero gives a zero of the same sign, and an infinity gives an infinity of the same sign. A NaN is returned with its sign and payload and with bit 22 set (quiet).
- R9: A subnormal operand with fraction f is taken as e = −127 − (number of leading zeros of the 23-bit f). m is f shifted left until its top set bit becomes the hidden bit.
- R10: op_i codes 5, 6 and 7 give result_o = 0.
- R11: For every finite normal operand x, the R2 mantissa scaled by 2^-(R4 result) equals x exactly. The R3 mantissa scaled by 2^(2·R5 result) also equals x exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code: 0 reciprocal mantissa, 1 square-root mantissa, 2 reciprocal exponent, 3 square-root exponent, 4 reciprocal-square-root exponent |
| operand_i | input | 32 | Single-precision operand |
| result_o | output | 32 | Float mantissa or two's-complement integer, as the operation code selects |

## Verification
All mantissa and exponent results, including the special values, go through a single register, so each one is due exactly one rising edge after its operands are applied. The bench changes the inputs on a falling edge and compares result_o with its behavioural model on the next falling edge, so exactly one rising edge lies between stimulus and sample. For the reconstruction checks, the bench runs the mantissa and exponent codes for the same operand on back-to-back cycles and combines the two sampled results. The bound checker only compares result_o with the inputs of the previous cycle, and only from the second edge after reset onward.

// File: rtl/frexp_pkg.sv
`timescale 1ns/1ps
package frexp_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned OP_W   = 3;
  localparam int unsigned E_W    = EXP_W + 2;  // unbiased exponent incl. subnormal range
  localparam int unsigned LZ_W   = $clog2(FRAC_W + 1);
  localparam int          BIAS   = (1 << (EXP_W - 1)) - 1;

  typedef enum logic [OP_W-1:0] {
    OP_RCP_MANT  = 3'd0,
    OP_SQRT_MANT = 3'd1,
    OP_RCP_EXP   = 3'd2,
    OP_SQRT_EXP  = 3'd3,
    OP_RSQ_EXP   = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    EK_RCP  = 2'd0,
    EK_SQRT = 2'd1,
    EK_RSQ  = 2'd2
  } exp_kind_e;

  typedef struct packed {
    logic                   sign;
    logic                   is_zero;
    logic                   is_inf;
    logic                   is_nan;
    logic signed [E_W-1:0]  exp;
    logic [FRAC_W-1:0]      frac;  // normalised fraction; raw payload for NaN
  } unpacked_t;
endpackage

// File: rtl/frexp_unpack.sv
`timescale 1ns/1ps
module frexp_unpack
  import frexp_pkg::*;
(
  input  logic [DATA_W-1:0] x_i,
  output unpacked_t         u_o
);
  logic [EXP_W-1:0]  ef;
  logic [FRAC_W-1:0] fr;
  logic [LZ_W-1:0]   lz;
  logic              ef_zero, ef_ones;

  assign ef      = x_i[DATA_W-2 -: EXP_W];
  assign fr      = x_i[FRAC_W-1:0];
  assign ef_zero = (ef == '0);
  assign ef_ones = (ef == '1);

  // leading zeros of the fraction; last hit is the top set bit
  always_comb begin
    lz = LZ_W'(FRAC_W);
    for (int i = 0; i < FRAC_W; i++) begin
      if (fr[i]) lz = LZ_W'(FRAC_W - 1 - i);
    end
  end

  always_comb begin
    u_o.sign    = x_i[DATA_W-1];
    u_o.is_zero = ef_zero && (fr == '0);
    u_o.is_inf  = ef_ones && (fr == '0);
    u_o.is_nan  = ef_ones && (fr != '0);
    if (ef_zero) begin
      u_o.exp  = E_W'(-BIAS) - E_W'(lz);
      u_o.frac = fr << (lz + 1);
    end else begin
      u_o.exp  = E_W'(ef) - E_W'(BIAS);
      u_o.frac = fr;
    end
  end
endmodule

// File: rtl/frexp_mant.sv
`timescale 1ns/1ps
module frexp_mant
  import frexp_pkg::*;
(
  input  unpacked_t         u_i,
  input  logic              sqrt_i,
  output logic [DATA_W-1:0] m_o
);
  localparam logic [EXP_W-1:0] EF_HALF    = EXP_W'(BIAS - 1);
  localparam logic [EXP_W-1:0] EF_QUARTER = EXP_W'(BIAS - 2);

  logic [EXP_W-1:0] ef_out;

  // even e scales by 4, odd e by 2
  assign ef_out = (sqrt_i && !u_i.exp[0]) ? EF_QUARTER : EF_HALF;

  always_comb begin
    if (u_i.is_nan)       m_o = {u_i.sign, {EXP_W{1'b1}}, 1'b1, u_i.frac[FRAC_W-2:0]};
    else if (u_i.is_inf)  m_o = {u_i.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (u_i.is_zero) m_o = {u_i.sign, {(DATA_W-1){1'b0}}};
    else                  m_o = {u_i.sign, ef_out, u_i.frac};
  end
endmodule

// File: rtl/frexp_exp.sv
`timescale 1ns/1ps
module frexp_exp
  import frexp_pkg::*;
(
  input  unpacked_t         u_i,
  input  exp_kind_e         kind_i,
  output logic [DATA_W-1:0] e_o
);
  logic signed [DATA_W-1:0] e_w, half_w;

  assign e_w    = {{(DATA_W-E_W){u_i.exp[E_W-1]}}, u_i.exp};
  assign half_w = e_w >>> 1;  // floor(e/2)

  always_comb begin
    if (u_i.is_zero || u_i.is_inf || u_i.is_nan) begin
      e_o = '0;
    end else begin
      unique case (kind_i)
        EK_RCP:  e_o = ~e_w;            // -e-1
        EK_SQRT: e_o = half_w + 1;
        EK_RSQ:  e_o = ~half_w;         // -floor(e/2)-1
        default: e_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/frexp_unit.sv
`timescale 1ns/1ps
module frexp_unit
  import frexp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] result_o
);
  unpacked_t         unp;
  logic [DATA_W-1:0] mant_w, exp_w, res_d;
  logic              is_sqrt_mant;
  exp_kind_e         kind;

  frexp_unpack u_unpack (.x_i(operand_i), .u_o(unp));

  assign is_sqrt_mant = (op_i == OP_SQRT_MANT);

  always_comb begin
    unique case (op_i)
      OP_SQRT_EXP: kind = EK_SQRT;
      OP_RSQ_EXP:  kind = EK_RSQ;
      default:     kind = EK_RCP;
    endcase
  end

  frexp_mant u_mant (.u_i(unp), .sqrt_i(is_sqrt_mant), .m_o(mant_w));
  frexp_exp  u_exp  (.u_i(unp), .kind_i(kind), .e_o(exp_w));

  always_comb begin
    unique case (op_i)
      OP_RCP_MANT, OP_SQRT_MANT:          res_d = mant_w;
      OP_RCP_EXP, OP_SQRT_EXP, OP_RSQ_EXP: res_d = exp_w;
      default:                            res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) result_o <= '0;
    else         result_o <= res_d;
  end
endmodule

// File: rtl/frexp_unit_chk.sv
`timescale 1ns/1ps
module frexp_unit_chk
  import frexp_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [DATA_W-1:0] result_o
);
  logic seen_q;
  logic in_normal, in_special;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assign in_normal  = (operand_i[30:23] != 8'h00) && (operand_i[30:23] != 8'hff);
  assign in_special = (operand_i[30:23] == 8'hff) || (operand_i[30:0] == '0);

  always @(negedge clk_i) begin
    if (!rst_ni) AST_RESET_ZERO: assert (result_o == '0); // R1
  end

  AST_RCP_MANT_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(op_i) == 3'd0 && $past(in_normal) |->
      result_o[30:23] == 8'd126 && result_o[31] == $past(operand_i[31]) &&
      result_o[22:0] == $past(operand_i[22:0])); // R2

  AST_SQRT_MANT_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(op_i) == 3'd1 && $past(in_normal) |->
      result_o[30:23] == ($past(operand_i[23]) ? 8'd125 : 8'd126)); // R3

  AST_RCP_EXP_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(op_i) == 3'd2 && $past(in_normal) |->
      result_o == 32'(126 - int'($past(operand_i[30:23])))); // R4

  AST_EXP_SPECIAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(op_i) >= 3'd2 && $past(op_i) <= 3'd4 && $past(in_special) |->
      result_o == '0); // R7

  AST_MANT_INF_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(op_i) <= 3'd1 && $past(operand_i[30:0]) == 31'h7f800000 |->
      result_o == $past(operand_i)); // R8

  AST_BAD_OP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(op_i) >= 3'd5 |-> result_o == '0); // R10
endmodule

bind frexp_unit frexp_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i),
  .operand_i(operand_i), .result_o(result_o)
);

// File: tb/tb_frexp_unit.sv
`timescale 1ns/1ps
module tb_frexp_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [2:0]  op_i;
  logic [31:0] operand_i;
  logic [31:0] result_o;
  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [31:0] last_res;

  always #2 clk_i = ~clk_i;

  frexp_unit dut (.clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i),
                  .operand_i(operand_i), .result_o(result_o));

  function automatic logic [31:0] model(int op, logic [31:0] x);
    int s, ebits, f, e, p, fh, mf;
    s = x[31]; ebits = x[30:23]; f = x[22:0];
    if (op > 4) return 32'h0;
    if (ebits == 255 || (ebits == 0 && f == 0)) begin
      if (op >= 2) return 32'h0;
      if (ebits == 255 && f != 0) return x | 32'h0040_0000;
      return x;
    end
    if (ebits == 0) begin
      p = 0;
      for (int i = 0; i < 23; i++) if (f & (1 << i)) p = i;
      e = p - 149;
      mf = (f << (23 - p)) & 32'h7f_ffff;
    end else begin
      e = ebits - 127;
      mf = f;
    end
    fh = (e >= 0) ? e / 2 : -((1 - e) / 2);
    case (op)
      0: return {s[0], 8'd126, mf[22:0]};
      1: return {s[0], ((e % 2) == 0) ? 8'd125 : 8'd126, mf[22:0]};
      2: return 32'(-e - 1);
      3: return 32'(fh + 1);
      default: return 32'(-fh - 1);
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // called at a falling edge; samples at the next one (one rising edge between)
  task automatic drive(int op, logic [31:0] x, string req);
    logic [31:0] exp;
    op_i = op[2:0]; operand_i = x;
    exp = model(op, x);
    @(negedge clk_i);
    last_res = result_o;
    check(req, result_o, exp);
  endtask

  task automatic recon(logic [31:0] x);
    logic [31:0] rm, re, sm, se, rs;
    drive(0, x, "R2"); rm = last_res;
    drive(2, x, "R4"); re = last_res;
    drive(1, x, "R3"); sm = last_res;
    drive(3, x, "R5"); se = last_res;
    drive(4, x, "R6"); rs = last_res;
    check("R11 rcp", {rm[31], 8'(int'(rm[30:23]) - int'(signed'(re))), rm[22:0]}, x);
    check("R11 sqrt", {sm[31], 8'(int'(sm[30:23]) + 2 * int'(signed'(se))), sm[22:0]}, x);
    check("R6 sum", rs + se, 32'h0);
  endtask

  function automatic string tag_of(int op);
    case (op)
      0: return "R2"; 1: return "R3"; 2: return "R4";
      3: return "R5"; 4: return "R6"; default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; op_i = 3'd0; operand_i = 32'h3f80_0000;
    repeat (3) @(negedge clk_i);
    check("R1 reset", result_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: first result after reset release is for the held inputs
    check("R1 latency", result_o, 32'h3f00_0000);
    // 1.0: e = 0
    drive(0, 32'h3f80_0000, "R2");
    drive(1, 32'h3f80_0000, "R3");
    drive(2, 32'h3f80_0000, "R4");
    drive(3, 32'h3f80_0000, "R5");
    drive(4, 32'h3f80_0000, "R6");
    // 2.0 odd e, -3.0 odd e negative sign, 0.125 e=-3 floor case
    drive(1, 32'h4000_0000, "R3");
    drive(0, 32'hc040_0000, "R2");
    drive(1, 32'hc040_0000, "R3");
    drive(3, 32'h3e00_0000, "R5");
    drive(4, 32'h3e00_0000, "R6");
    drive(2, 32'h7f7f_ffff, "R4");
    // subnormals: smallest, top-bit, mid
    drive(2, 32'h0000_0001, "R9");
    drive(0, 32'h0000_0001, "R9");
    drive(1, 32'h0040_0000, "R9");
    drive(3, 32'h8000_0003, "R9");
    drive(4, 32'h0001_2345, "R9");
    // specials
    for (int op = 0; op < 5; op++) begin
      drive(op, 32'h0000_0000, op < 2 ? "R8" : "R7");
      drive(op, 32'h8000_0000, op < 2 ? "R8" : "R7");
      drive(op, 32'h7f80_0000, op < 2 ? "R8" : "R7");
      drive(op, 32'hff80_0000, op < 2 ? "R8" : "R7");
      drive(op, 32'h7fa0_0001, op < 2 ? "R8" : "R7");
      drive(op, 32'hffc0_0000, op < 2 ? "R8" : "R7");
    end
    for (int op = 5; op < 8; op++) drive(op, 32'h3f80_0000, "R10");
    // reconstruction on normals
    recon(32'h3f80_0000);
    recon(32'hc2f6_e979);
    recon(32'h0080_0000);
    for (int k = 0; k < 150; k++) begin
      logic [31:0] x;
      x = $urandom;
      x[30:23] = 8'($urandom_range(1, 254));
      recon(x);
    end
    for (int k = 0; k < 600; k++) begin
      int op;
      op = $urandom_range(0, 7);
      drive(op, $urandom, tag_of(op));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule